// File: doc/BRIEF.md
# Command Completion Event Counter

This block sits beside one channel of a multi-channel DMA engine and tells software how many command completions have occurred that it has not yet handled. A hardware-owned done count advances by one for every event pulse from the descriptor fetcher. A software-owned handled count records how far software has caught up. Both counts sit in one status word, together with a sticky interrupt-active flag.

Software reads the word and takes the difference of the two counts, modulo 2^CNT_W, as the number of new events. It then acknowledges by writing back the done count it saw as the new handled count. In the same write it clears the flag. An event that lands during that sequence still advances the done count, so the difference stays non-zero and the interrupt stays up. Nothing is lost. Three configuration inputs, which come from the channel's general configuration word, gate the single interrupt line and choose between level and pulse signalling.

Top module: `evt_done_counter`

## Requirements
- R1: After reset, the status word reads all zeros and the interrupt line is low.
- R2: Each cycle with `evt_i` high increments the done field (status bits 5:0) by one, wrapping from 63 to 0. This is visible in the cycle after the event.
- R3: A write (`wr_i` high) loads status bits 21:16 (the handled count) from `wdata_i[21:16]`. Write data in the done field has no effect, and all status bits outside 21:16, 8 and 5:0 read as zero.
- R4: The active flag (status bit 8) is set by every event. It stays set until a write with `wdata_i[8]` = 0. A write with `wdata_i[8]` = 1 leaves it unchanged.
- R5: When an event and a write occur in the same cycle, the done field still increments and the active flag ends up set.
- R6: In level mode (`level_mode_i` = 1), with `cmd_irq_en_i` or `list_irq_en_i` high, `irq_o` is high exactly when the done and handled fields differ or the active flag is set.
- R7: With both enable inputs low, `irq_o` stays low whatever the counters and flag hold.
- R8: In pulse mode (`level_mode_i` = 0), with an enable high, `irq_o` is high for exactly the one cycle that follows each event cycle.
- R9: Pending events equal (done − handled) modulo 64. After 64 events, a handled count equal to the done count and a cleared flag give no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | One-cycle completion event pulse |
| wr_i | input | 1 | Status word write strobe |
| wdata_i | input | 32 | Status word write data |
| cmd_irq_en_i | input | 1 | Command interrupt enable (config bit 29) |
| list_irq_en_i | input | 1 | List interrupt enable (config bit 31) |
| level_mode_i | input | 1 | 1 = level interrupt, 0 = single-cycle pulse (config bit 28) |
| status_o | output | 32 | Status word: done, active flag, handled count |
| irq_o | output | 1 | Interrupt line |

## Verification
The sharpest case is an acknowledge write in the same cycle as a new event. A design that lets the write win would lose the increment, or would clear the flag. The interrupt would then fall while an unhandled completion exists.

The bench drives the done count past 63 to catch a counter that saturates or sign-extends its difference. It also brings the counter back level with a stale handled count after 64 events, which catches a design that treats "many events" as "pending".

It writes ones into the done field and the unused bits to expose a done counter that software can overwrite, and stray register bits. It also flips the enables and the mode bit. A design that ignores an enable, or holds a pulse-mode interrupt for more than one cycle, fails these checks.

// File: rtl/evt_done_pkg.sv
package evt_done_pkg;
  localparam int ARITH_W = 16;

  // Number of events not yet handled, modulo 2^w.
  function automatic logic [ARITH_W-1:0] fn_pending(input logic [ARITH_W-1:0] done,
                                                     input logic [ARITH_W-1:0] handled,
                                                     input int w);
    logic [ARITH_W-1:0] mask;
    mask = (ARITH_W'(1) << w) - ARITH_W'(1);
    return (done - handled) & mask;
  endfunction

  // Next value of a wrapping counter of width w.
  function automatic logic [ARITH_W-1:0] fn_wrap_inc(input logic [ARITH_W-1:0] v,
                                                      input int w);
    logic [ARITH_W-1:0] mask;
    mask = (ARITH_W'(1) << w) - ARITH_W'(1);
    return (v + ARITH_W'(1)) & mask;
  endfunction
endpackage

// File: rtl/evt_done_ctr.sv
module evt_done_ctr
  import evt_done_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  output logic [CNT_W-1:0] done_o
);
  logic [CNT_W-1:0] done_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      done_q <= '0;
    else if (evt_i)
      done_q <= CNT_W'(fn_wrap_inc(ARITH_W'(done_q), CNT_W));
  end

  assign done_o = done_q;
endmodule

// File: rtl/evt_ack_reg.sv
module evt_ack_reg #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] handled_wdata_i,
  input  logic             active_wdata_i,
  output logic [CNT_W-1:0] handled_o,
  output logic             active_o
);
  logic [CNT_W-1:0] handled_q;
  logic             active_q;
  logic             clear_req;

  // A clear request loses against a concurrent event.
  assign clear_req = wr_i && !active_wdata_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      handled_q <= '0;
      active_q  <= 1'b0;
    end else begin
      if (wr_i)
        handled_q <= handled_wdata_i;
      if (evt_i)
        active_q <= 1'b1;
      else if (clear_req)
        active_q <= 1'b0;
    end
  end

  assign handled_o = handled_q;
  assign active_o  = active_q;
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen
  import evt_done_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] done_i,
  input  logic [CNT_W-1:0] handled_i,
  input  logic             active_i,
  input  logic             enable_i,
  input  logic             level_i,
  output logic [CNT_W-1:0] pending_o,
  output logic             irq_o
);
  logic evt_seen_q;
  logic level_req;

  always_ff @(posedge clk) begin
    if (!rst_n)
      evt_seen_q <= 1'b0;
    else
      evt_seen_q <= evt_i;
  end

  assign pending_o = CNT_W'(fn_pending(ARITH_W'(done_i), ARITH_W'(handled_i), CNT_W));
  assign level_req = (|pending_o) || active_i;
  assign irq_o     = enable_i && (level_i ? level_req : evt_seen_q);
endmodule

// File: rtl/evt_done_counter.sv
module evt_done_counter #(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 6,
  parameter int DONE_LSB = 0,
  parameter int ACT_BIT  = 8,
  parameter int HND_LSB  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cmd_irq_en_i,
  input  logic              list_irq_en_i,
  input  logic              level_mode_i,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  localparam int DONE_MSB = DONE_LSB + CNT_W - 1;
  localparam int HND_MSB  = HND_LSB + CNT_W - 1;

  logic [CNT_W-1:0] done_cnt;
  logic [CNT_W-1:0] handled_cnt;
  logic [CNT_W-1:0] pending_cnt;
  logic             active_flag;
  logic             irq_enable;
  logic [CNT_W-1:0] wr_handled;
  logic             wr_active;
  logic             unused_wdata;

  assign wr_handled   = wdata_i[HND_MSB:HND_LSB];
  assign wr_active    = wdata_i[ACT_BIT];
  assign unused_wdata = ^wdata_i;
  assign irq_enable   = cmd_irq_en_i || list_irq_en_i;

  evt_done_ctr #(.CNT_W(CNT_W)) u_done (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .done_o (done_cnt)
  );

  evt_ack_reg #(.CNT_W(CNT_W)) u_ack (
    .clk             (clk),
    .rst_n           (rst_n),
    .evt_i           (evt_i),
    .wr_i            (wr_i),
    .handled_wdata_i (wr_handled),
    .active_wdata_i  (wr_active),
    .handled_o       (handled_cnt),
    .active_o        (active_flag)
  );

  evt_irq_gen #(.CNT_W(CNT_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .done_i    (done_cnt),
    .handled_i (handled_cnt),
    .active_i  (active_flag),
    .enable_i  (irq_enable),
    .level_i   (level_mode_i),
    .pending_o (pending_cnt),
    .irq_o     (irq_o)
  );

  always_comb begin
    status_o                    = '0;
    status_o[DONE_MSB:DONE_LSB] = done_cnt;
    status_o[ACT_BIT]           = active_flag;
    status_o[HND_MSB:HND_LSB]   = handled_cnt;
  end
endmodule

// File: rtl/evt_done_checker.sv
module evt_done_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt,
  input logic             wr,
  input logic [CNT_W-1:0] wr_handled,
  input logic             wr_active,
  input logic [CNT_W-1:0] done,
  input logic [CNT_W-1:0] handled,
  input logic [CNT_W-1:0] pending,
  input logic             active,
  input logic             enable,
  input logic             level,
  input logic             irq
);
  AST_DONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> done == CNT_W'($past(done) + CNT_W'(1))); // R2
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(done)); // R3
  AST_HANDLED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> handled == $past(wr_handled)); // R3
  AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(wr && !wr_active)) |=> active); // R4
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> active); // R5
  AST_LEVEL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (level && enable && pending != '0) |-> irq); // R6
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !irq); // R7
  AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!level && irq) |-> $past(evt)); // R8
endmodule

bind evt_done_counter evt_done_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt        (evt_i),
  .wr         (wr_i),
  .wr_handled (wr_handled),
  .wr_active  (wr_active),
  .done       (done_cnt),
  .handled    (handled_cnt),
  .pending    (pending_cnt),
  .active     (active_flag),
  .enable     (irq_enable),
  .level      (level_mode_i),
  .irq        (irq_o)
);

// File: tb/evt_done_counter_bench.sv
`timescale 1ns/1ps
module evt_done_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        cmd_en = 1'b0;
  logic        list_en = 1'b0;
  logic        level = 1'b1;
  logic [31:0] status;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Bench's own view of the block
  int unsigned m_done = 0;
  int unsigned m_hnd = 0;
  bit m_act = 0;
  bit m_last_evt = 0;

  always #5 clk = ~clk;

  evt_done_counter u_evt_done_counter (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_i         (evt),
    .wr_i          (wr),
    .wdata_i       (wdata),
    .cmd_irq_en_i  (cmd_en),
    .list_irq_en_i (list_en),
    .level_mode_i  (level),
    .status_o      (status),
    .irq_o         (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[5:0]   = 6'(m_done);
    s[8]     = m_act;
    s[21:16] = 6'(m_hnd);
    return s;
  endfunction

  function automatic logic exp_irq();
    logic en = cmd_en | list_en;
    if (!en) return 1'b0;
    if (level) return ((m_done % 64) != (m_hnd % 64)) || m_act;
    return m_last_evt;
  endfunction

  // One clock: apply inputs, update model, sample at the following falling edge.
  task automatic step(input bit e, input bit w, input logic [31:0] d);
    evt = e; wr = w; wdata = d;
    @(posedge clk);
    if (e) m_done = (m_done + 1) % 64;
    if (w) m_hnd = d[21:16];
    if (e) m_act = 1;
    else if (w && !d[8]) m_act = 0;
    m_last_evt = e;
    @(negedge clk);
    evt = 0; wr = 0; wdata = '0;
  endtask

  task automatic check_state(input string req);
    check({req, " status"}, status, exp_status());
    check({req, " irq"}, {31'b0, irq}, {31'b0, exp_irq()});
  endtask

  task automatic t_reset();
    check("R1 status", status, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_count();
    cmd_en = 1; level = 1;
    for (int i = 0; i < 3; i++) begin
      step(1, 0, '0);
      check_state("R2 count");
    end
    check("R6 irq with pending", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_ack();
    // ack with ones in the done field and stray bits: done must not move
    step(0, 1, 32'hFC03_FEFF & ~32'h0000_0100 | (32'(3) << 16));
    check_state("R3 ack");
    check("R3 done unchanged", {26'b0, status[5:0]}, 32'd3);
    check("R6 irq low after ack", {31'b0, irq}, 32'h0);
    step(1, 0, '0);
    step(0, 1, (32'(4) << 16) | 32'h100);
    check_state("R4 flag kept on write of 1");
    check("R4 active", {31'b0, status[8]}, 32'h1);
    step(0, 1, (32'(4) << 16));
    check_state("R4 flag cleared");
  endtask

  task automatic t_race();
    int unsigned seen;
    step(1, 0, '0);
    seen = status[5:0];
    step(1, 1, 32'(seen) << 16);
    check_state("R5 event during ack");
    check("R9 pending one", 32'((m_done - m_hnd) % 64), 32'd1);
    check("R5 irq stays", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_wrap();
    step(0, 1, 32'(m_done) << 16);
    for (int i = 0; i < 64; i++) step(1, 0, '0);
    check_state("R2 wrap");
    step(0, 1, 32'(m_done) << 16);
    check_state("R9 full lap");
    check("R9 no irq", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 70; i++) step(1, 0, '0);
    check_state("R2 wrap past 63");
  endtask

  task automatic t_enables();
    cmd_en = 0; list_en = 0;
    #1;
    check_state("R7 disabled");
    check("R7 irq low", {31'b0, irq}, 32'h0);
    list_en = 1;
    #1;
    check_state("R6 list enable");
  endtask

  task automatic t_pulse();
    step(0, 1, 32'(m_done) << 16);
    level = 0;
    #1;
    check("R8 idle", {31'b0, irq}, 32'h0);
    step(1, 0, '0);
    check("R8 pulse high", {31'b0, irq}, 32'h1);
    step(0, 0, '0);
    check("R8 pulse one cycle", {31'b0, irq}, 32'h0);
    step(1, 0, '0);
    step(1, 0, '0);
    check_state("R8 back to back");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_count();
    t_ack();
    t_race();
    t_wrap();
    t_enables();
    t_pulse();
    finish_run();
  end
endmodule